// File: doc/BRIEF.md
# NAND Flash Command/Address/Data Bridge

This block turns simple host bus cycles into the pin-level cycles of an 8-bit or 16-bit NAND flash device. Commands, NAND addresses and data all travel over the device data bus. The host address does not reach the device. It only decides what kind of device cycle a host access becomes: a command cycle, an address cycle or a data cycle. It also picks one of two banks, the regular bank or the special bank. Each bank has its own setup, strobe-width and hold counts.

A host word that is wider than the memory is sent as several memory-width beats, least significant part first. Reads are rebuilt from those beats in the same order. The device ready/busy line is monitored. While it reads busy, a data read beat waits and the host is stalled. The host holds a request until it receives a one-cycle acknowledge.

Top module: `nandb_bridge`

## Requirements
- R1: Section decode from the host address. If bit 17 is 1, the access goes to the address section and `nand_ale` is 1 while chip enable is low. Otherwise, if bit 16 is 1, the access goes to the command section and `nand_cle` is 1. If both bits are 0, the access goes to the data section and both latch lines are 0. `nand_cle` and `nand_ale` are never both 1.
- R2: A write to the command or address section makes exactly one write strobe. During it, `nand_dq_o[7:0]` equals host data bits [7:0] and `nand_dq_o[15:8]` is 0.
- R3: A data-section write is split into beats, least significant part first. With `nand_wide`=0 there are four 8-bit beats. With `nand_wide`=1 there are two 16-bit beats. Each beat makes one write strobe.
- R4: With `nand_wide`=0, `nand_dq_o[15:8]` is 0 and `nand_dq_i[15:8]` has no effect on read data.
- R5: A data-section read makes the same beats with the read strobe. Each beat samples `nand_dq_i` in the last strobe cycle and places it in the host word, least significant part first.
- R6: Host address bit 20 selects the timing set: 0 selects the regular set and 1 selects the special set. Each beat has S setup cycles, then W strobe cycles, then H hold cycles. A count of 0 is treated as 1. A write acknowledges 1+N·(S+W+H) cycles after the request is accepted, where N is the beat count.
- R7: A data read beat does not start while `nand_rb` is 0 (busy). Each read beat first spends one cycle checking ready, plus one more cycle for every cycle that busy persists. An unstalled read acknowledges after 1+N·(1+S+W+H) cycles.
- R8: `nand_ce_n` is low for the whole transaction and high when idle. `nand_we_n` and `nand_re_n` are never both low, and a strobe occurs only while `nand_ce_n` is low. `nand_dq_oe` is 1 only during writes.
- R9: `host_ack` is high for exactly one cycle. A request is not accepted in the cycle in which acknowledge is high. A read of the command or address section acknowledges after one cycle, returns zero and does not assert chip enable.
- R10: After reset the block is idle: `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `host_ack` is 0, and `nand_dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host address (selects section and bank) |
| host_wdata | input | HOST_W | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | HOST_W | Read data, valid with acknowledge |
| nand_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| reg_setup | input | TW | Regular bank setup count |
| reg_strobe | input | TW | Regular bank strobe count |
| reg_hold | input | TW | Regular bank hold count |
| spc_setup | input | TW | Special bank setup count |
| spc_strobe | input | TW | Special bank strobe count |
| spc_hold | input | TW | Special bank hold count |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Device bus output value |
| nand_dq_oe | output | 1 | Device bus output enable |
| nand_dq_i | input | 16 | Device bus input value |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
Two events can fall in the same cycle. The first is the release of busy and the check that gates the start of a read beat. The bench holds `nand_rb` low for a chosen number of cycles around the accept edge. It then judges that the acknowledge latency grows by exactly that many cycles, and that no read strobe appears while busy is low. The second is the acknowledge cycle and a still-held request. The bench keeps the request high through the acknowledge cycle and checks that chip enable stays high afterwards.

// File: rtl/nandb_pkg.sv
package nandb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READY  = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        SEC_DATA = 2'd0,
        SEC_CMD  = 2'd1,
        SEC_ADDR = 2'd2
    } sect_e;

endpackage

// File: rtl/nandb_decode.sv
module nandb_decode
    import nandb_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CLE_BIT  = 16,
    parameter int ALE_BIT  = 17,
    parameter int BANK_BIT = 20
) (
    input  logic [AW-1:0] addr,
    output sect_e         sect,
    output logic          bank
);
    logic unused_addr_bits;
    assign unused_addr_bits = &{1'b0, addr};

    always_comb begin
        if (addr[ALE_BIT]) begin
            sect = SEC_ADDR;
        end else if (addr[CLE_BIT]) begin
            sect = SEC_CMD;
        end else begin
            sect = SEC_DATA;
        end
        bank = addr[BANK_BIT];
    end
endmodule

// File: rtl/nandb_tsel.sv
module nandb_tsel #(
    parameter int TW = 4
) (
    input  logic          bank,
    input  logic [TW-1:0] reg_setup,
    input  logic [TW-1:0] reg_strobe,
    input  logic [TW-1:0] reg_hold,
    input  logic [TW-1:0] spc_setup,
    input  logic [TW-1:0] spc_strobe,
    input  logic [TW-1:0] spc_hold,
    output logic [TW-1:0] len_setup,
    output logic [TW-1:0] len_strobe,
    output logic [TW-1:0] len_hold
);
    localparam int NBANK = 2;

    logic [TW-1:0] raw_s [NBANK];
    logic [TW-1:0] raw_w [NBANK];
    logic [TW-1:0] raw_h [NBANK];
    logic [TW-1:0] nrm_s [NBANK];
    logic [TW-1:0] nrm_w [NBANK];
    logic [TW-1:0] nrm_h [NBANK];

    assign raw_s[0] = reg_setup;
    assign raw_w[0] = reg_strobe;
    assign raw_h[0] = reg_hold;
    assign raw_s[1] = spc_setup;
    assign raw_w[1] = spc_strobe;
    assign raw_h[1] = spc_hold;

    // A zero count still occupies one cycle of its phase.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign nrm_s[b] = (raw_s[b] == '0) ? TW'(1) : raw_s[b];
        assign nrm_w[b] = (raw_w[b] == '0) ? TW'(1) : raw_w[b];
        assign nrm_h[b] = (raw_h[b] == '0) ? TW'(1) : raw_h[b];
    end

    assign len_setup  = nrm_s[bank];
    assign len_strobe = nrm_w[bank];
    assign len_hold   = nrm_h[bank];
endmodule

// File: rtl/nandb_lane.sv
module nandb_lane
    import nandb_pkg::*;
#(
    parameter int HOST_W = 32,
    parameter int BW     = 2
) (
    input  logic [HOST_W-1:0] wdata,
    input  logic [BW-1:0]     beat,
    input  logic              wide,
    input  sect_e             sect,
    input  logic [15:0]       dq_i,
    input  logic [HOST_W-1:0] racc,
    output logic [15:0]       dq_o,
    output logic [HOST_W-1:0] rnext
);
    int unsigned       shamt;
    logic [HOST_W-1:0] shifted;
    logic [HOST_W-1:0] ins;

    always_comb begin
        shamt   = wide ? 16 * int'(beat) : 8 * int'(beat);
        shifted = wdata >> shamt;
        if (sect != SEC_DATA) begin
            dq_o = {8'h00, wdata[7:0]};
        end else if (wide) begin
            dq_o = shifted[15:0];
        end else begin
            dq_o = {8'h00, shifted[7:0]};
        end
        ins   = wide ? HOST_W'(dq_i) : HOST_W'(dq_i[7:0]);
        rnext = racc | (ins << shamt);
    end
endmodule

// File: rtl/nandb_bridge.sv
module nandb_bridge
    import nandb_pkg::*;
#(
    parameter int HOST_W   = 32,
    parameter int AW       = 32,
    parameter int TW       = 4,
    parameter int CLE_BIT  = 16,
    parameter int ALE_BIT  = 17,
    parameter int BANK_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              nand_wide,
    input  logic [TW-1:0]     reg_setup,
    input  logic [TW-1:0]     reg_strobe,
    input  logic [TW-1:0]     reg_hold,
    input  logic [TW-1:0]     spc_setup,
    input  logic [TW-1:0]     spc_strobe,
    input  logic [TW-1:0]     spc_hold,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [15:0]       nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [15:0]       nand_dq_i,
    input  logic              nand_rb
);
    localparam int NB8  = HOST_W / 8;
    localparam int NB16 = HOST_W / 16;
    localparam int BW   = $clog2(NB8);

    typedef struct packed {
        phase_e            ph;
        logic [TW-1:0]     cnt;
        logic [BW-1:0]     beat;
        logic              we;
        sect_e             sect;
        logic              bank;
        logic [HOST_W-1:0] wdata;
        logic [HOST_W-1:0] rdata;
        logic              ack;
    } state_t;

    state_t q, d;

    sect_e             dec_sect;
    logic              dec_bank;
    logic              bank_now;
    logic [TW-1:0]     len_setup;
    logic [TW-1:0]     len_strobe;
    logic [TW-1:0]     len_hold;
    logic [15:0]       lane_dq;
    logic [HOST_W-1:0] lane_rnext;
    logic              last_beat;

    nandb_decode #(
        .AW      (AW),
        .CLE_BIT (CLE_BIT),
        .ALE_BIT (ALE_BIT),
        .BANK_BIT(BANK_BIT)
    ) u_dec (
        .addr(host_addr),
        .sect(dec_sect),
        .bank(dec_bank)
    );

    assign bank_now = (q.ph == PH_IDLE) ? dec_bank : q.bank;

    nandb_tsel #(.TW(TW)) u_tsel (
        .bank      (bank_now),
        .reg_setup (reg_setup),
        .reg_strobe(reg_strobe),
        .reg_hold  (reg_hold),
        .spc_setup (spc_setup),
        .spc_strobe(spc_strobe),
        .spc_hold  (spc_hold),
        .len_setup (len_setup),
        .len_strobe(len_strobe),
        .len_hold  (len_hold)
    );

    nandb_lane #(.HOST_W(HOST_W), .BW(BW)) u_lane (
        .wdata(q.wdata),
        .beat (q.beat),
        .wide (nand_wide),
        .sect (q.sect),
        .dq_i (nand_dq_i),
        .racc (q.rdata),
        .dq_o (lane_dq),
        .rnext(lane_rnext)
    );

    assign last_beat = (q.sect != SEC_DATA) ||
                       (int'(q.beat) == (nand_wide ? NB16 : NB8) - 1);

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (host_req && !q.ack) begin
                    d.we    = host_we;
                    d.sect  = dec_sect;
                    d.bank  = dec_bank;
                    d.wdata = host_wdata;
                    d.rdata = '0;
                    d.beat  = '0;
                    if (!host_we && dec_sect != SEC_DATA) begin
                        d.ack = 1'b1;
                    end else if (!host_we) begin
                        d.ph = PH_READY;
                    end else begin
                        d.ph  = PH_SETUP;
                        d.cnt = len_setup - 1'b1;
                    end
                end
            end
            PH_READY: begin
                if (nand_rb) begin
                    d.ph  = PH_SETUP;
                    d.cnt = len_setup - 1'b1;
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_STROBE;
                    d.cnt = len_strobe - 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_HOLD;
                    d.cnt = len_hold - 1'b1;
                    if (!q.we) begin
                        d.rdata = lane_rnext;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    if (last_beat) begin
                        d.ph  = PH_IDLE;
                        d.ack = 1'b1;
                    end else begin
                        d.beat = q.beat + 1'b1;
                        if (!q.we) begin
                            d.ph = PH_READY;
                        end else begin
                            d.ph  = PH_SETUP;
                            d.cnt = len_setup - 1'b1;
                        end
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph    <= PH_IDLE;
            q.cnt   <= '0;
            q.beat  <= '0;
            q.we    <= 1'b0;
            q.sect  <= SEC_DATA;
            q.bank  <= 1'b0;
            q.wdata <= '0;
            q.rdata <= '0;
            q.ack   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign host_ack   = q.ack;
    assign host_rdata = q.rdata;
    assign nand_ce_n  = (q.ph == PH_IDLE);
    assign nand_cle   = (q.ph != PH_IDLE) && (q.sect == SEC_CMD);
    assign nand_ale   = (q.ph != PH_IDLE) && (q.sect == SEC_ADDR);
    assign nand_we_n  = !((q.ph == PH_STROBE) && q.we);
    assign nand_re_n  = !((q.ph == PH_STROBE) && !q.we);
    assign nand_dq_oe = (q.ph != PH_IDLE) && q.we;
    assign nand_dq_o  = nand_dq_oe ? lane_dq : 16'h0000;

    // R1: the two latch lines are exclusive
    a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R8: one strobe at a time, only inside chip enable, bus not driven on reads
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    a_r8_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    // R7: a busy device keeps the read beat waiting
    a_r7_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_READY && !nand_rb) |=> (q.ph == PH_READY));

    // R9: acknowledge is a single-cycle pulse
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R4: upper byte is quiet on a narrow device
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_dq_oe && !nand_wide) |-> (nand_dq_o[15:8] == 8'h00));
endmodule

// File: tb/sim_nandb_bridge.sv
module sim_nandb_bridge;
    localparam int HW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        nand_wide = 1'b0;
    logic [3:0]  rs = 4'd1, rw = 4'd1, rh = 4'd1;
    logic [3:0]  ss = 4'd1, sw = 4'd1, sh = 4'd1;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_o;
    logic [15:0] nand_dq_i = '0;
    logic        nand_rb = 1'b1;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;

    always #4 clk = ~clk;

    nandb_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .nand_wide(nand_wide),
        .reg_setup(rs), .reg_strobe(rw), .reg_hold(rh),
        .spc_setup(ss), .spc_strobe(sw), .spc_hold(sh),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    // pin monitor state
    int          np;
    logic [15:0] p_dq [8];
    logic        p_cle [8];
    logic        p_ale [8];
    logic        p_wr [8];
    int          cur_w, exp_w, bad_w, bad_rb, ce_seen, bad_oe;
    logic        prev_str = 1'b0;
    logic [15:0] rbase;

    always @(posedge clk) ncyc <= ncyc + 1;

    always @(negedge clk) begin
        logic str;
        str = !nand_we_n || !nand_re_n;
        if (!nand_ce_n) ce_seen++;
        if (!nand_re_n && !nand_rb) bad_rb++;
        if (!nand_re_n && nand_dq_oe) bad_oe++;
        if (str && !prev_str) begin
            if (np < 8) begin
                p_dq[np]  = nand_dq_o;
                p_cle[np] = nand_cle;
                p_ale[np] = nand_ale;
                p_wr[np]  = !nand_we_n;
            end
            if (!nand_re_n) nand_dq_i = rbase + 16'h1357 * 16'(np);
            np++;
            cur_w = 1;
        end else if (str) begin
            cur_w++;
        end
        if (!str && prev_str && cur_w != exp_w) bad_w++;
        prev_str = str;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int mx1(input logic [3:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic logic [15:0] exp_beat(input int sect, input logic wide,
                                             input logic [31:0] wd, input int p);
        if (sect != 0) return {8'h00, wd[7:0]};
        if (wide) return wd[p*16 +: 16];
        return {8'h00, wd[p*8 +: 8]};
    endfunction

    // One host transaction; busy cycles hold ready low at start; extra holds req through ack.
    task automatic run(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                       input int busy, input bit extra);
        int sect, n, s, w, h, lat, cyc;
        logic bank;
        logic [31:0] er, got;
        sect = addr[17] ? 2 : (addr[16] ? 1 : 0);
        bank = addr[20];
        s = mx1(bank ? ss : rs);
        w = mx1(bank ? sw : rw);
        h = mx1(bank ? sh : rh);
        n = (sect != 0) ? 1 : (nand_wide ? 2 : 4);
        if (we) lat = 1 + n * (s + w + h);
        else if (sect != 0) lat = 1;
        else lat = 1 + n * (1 + s + w + h) + busy;
        exp_w = w;
        np = 0; bad_w = 0; bad_rb = 0; ce_seen = 0; bad_oe = 0;
        rbase = 16'($urandom);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
        if (busy > 0 && !we) nand_rb = 1'b0;
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1 + busy) nand_rb = 1'b1;
            if (host_ack || cyc > 400) break;
        end
        got = host_rdata;
        if (extra) begin
            @(negedge clk);
            host_req = 1'b0;
            @(negedge clk);
            chk(nand_ce_n == 1'b1, "R9 request held in ack cycle not accepted", 64'(nand_ce_n), 64'd1);
        end
        host_req = 1'b0;
        nand_rb = 1'b1;
        chk(cyc == lat, "R6/R7 acknowledge latency", 64'(cyc), 64'(lat));
        if (!we && sect != 0) begin
            chk(got == 0, "R9 control-section read data", 64'(got), 64'd0);
            chk(ce_seen == 0, "R9 control-section read chip enable", 64'(ce_seen), 64'd0);
        end else begin
            chk(np == n, "R3 strobe count", 64'(np), 64'(n));
            chk(bad_w == 0, "R6 strobe width", 64'(bad_w), 64'd0);
            chk(ce_seen == lat - 1, "R8 chip enable span", 64'(ce_seen), 64'(lat - 1));
            for (int p = 0; p < n && p < 8; p++) begin
                chk(p_cle[p] == (sect == 1), "R1 command latch line", 64'(p_cle[p]), 64'(sect == 1));
                chk(p_ale[p] == (sect == 2), "R1 address latch line", 64'(p_ale[p]), 64'(sect == 2));
                chk(p_wr[p] == we, "R8 strobe kind", 64'(p_wr[p]), 64'(we));
                if (we) chk(p_dq[p] == exp_beat(sect, nand_wide, wd, p),
                            (sect != 0) ? "R2 control beat value" : "R3 R4 data beat value",
                            64'(p_dq[p]), 64'(exp_beat(sect, nand_wide, wd, p)));
            end
            if (!we) begin
                er = '0;
                for (int p = 0; p < n; p++) begin
                    logic [15:0] v;
                    v = rbase + 16'h1357 * 16'(p);
                    if (nand_wide) er[p*16 +: 16] = v;
                    else er[p*8 +: 8] = v[7:0];
                end
                chk(got == er, "R5 R4 read assembly", 64'(got), 64'(er));
                chk(bad_rb == 0, "R7 no read strobe while busy", 64'(bad_rb), 64'd0);
                chk(bad_oe == 0, "R8 bus not driven on read", 64'(bad_oe), 64'd0);
            end
        end
    endtask

    initial begin
        while (ncyc < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", ncyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2741));
        repeat (3) @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n && !host_ack && !nand_dq_oe,
            "R10 reset idle", 64'({nand_ce_n, nand_we_n, nand_re_n, host_ack, nand_dq_oe}), 64'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corner cases
        rs = 4'd2; rw = 4'd3; rh = 4'd1; ss = 4'd1; sw = 4'd1; sh = 4'd4;
        run(1'b1, 32'h0001_0000, 32'hFFFF_FF70, 0, 1'b0);   // R2 command write
        run(1'b1, 32'h0002_0000, 32'h0000_A5C3, 0, 1'b0);   // R2 address write
        run(1'b1, 32'h0000_0000, 32'h1234_5678, 0, 1'b0);   // R3 8-bit data write
        nand_wide = 1'b1;
        run(1'b1, 32'h0010_0000, 32'hCAFE_BEEF, 0, 1'b0);   // R6 special bank 16-bit
        run(1'b0, 32'h0000_0000, 32'h0, 0, 1'b0);           // R5 16-bit read
        nand_wide = 1'b0;
        run(1'b0, 32'h0010_0000, 32'h0, 0, 1'b0);           // R4 upper input ignored
        rs = 4'd0; rw = 4'd0; rh = 4'd0;
        run(1'b1, 32'h0000_0040, 32'h0BAD_F00D, 0, 1'b0);   // R6 zero counts act as one
        run(1'b0, 32'h0000_0000, 32'h0, 5, 1'b0);           // R7 busy stall
        run(1'b0, 32'h0000_0000, 32'h0, 1, 1'b0);           // R7 release on first check
        run(1'b0, 32'h0001_0000, 32'h0, 0, 1'b0);           // R9 control-section read
        run(1'b1, 32'h0003_0000, 32'h0000_0099, 0, 1'b1);   // R1 both bits, R9 held request
        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            rs = 4'($urandom_range(0, 3)); rw = 4'($urandom_range(0, 3)); rh = 4'($urandom_range(0, 3));
            ss = 4'($urandom_range(0, 3)); sw = 4'($urandom_range(0, 3)); sh = 4'($urandom_range(0, 3));
            nand_wide = 1'($urandom);
            a = {11'h0, 1'($urandom), 2'h0, 2'($urandom), 16'($urandom)};
            run(1'($urandom), a, $urandom, int'($urandom_range(0, 3)), 1'($urandom));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule